// File: doc/BRIEF.md
# Adaptive Equalizer Level Selector

This block chooses the receive equalization level of a line interface. A peak detector downstream of the equalizer reports an 8-bit amplitude count with a one-cycle valid strobe. The block compares every such count against a programmable window formed by a high and a low threshold. A count above the window means the signal is over-equalized, so the level steps down by one. A count below the window means more equalization is needed, so the level steps up by one. A count inside the window leaves the level alone.

The comparison rule applies only while automatic equalization is enabled. After every level change, a programmable number of following samples is skipped so that the analog equalizer can settle before it is judged again. The level saturates at both ends. If software programs a window whose low edge lies above its high edge, the block makes no changes. A small write port loads the threshold word and the settling length.

Top module: `eq_level_sel`

## Requirements
- R1: After reset the level is 0, both thresholds are 0 and the settling length is 16 samples.
- R2: A write with `cfg_sel`=0 loads the high threshold from `cfg_wdata[15:8]` and the low threshold from `cfg_wdata[7:0]`. A write with `cfg_sel`=1 loads the settling length from `cfg_wdata[7:0]`. The new values apply to samples from the next cycle on.
- R3: A considered sample whose count is strictly greater than the high threshold lowers the level by one. The new level is visible one cycle after the strobe.
- R4: A considered sample whose count is strictly less than the low threshold raises the level by one. The new level is visible one cycle after the strobe.
- R5: A sample whose count lies between the low and high thresholds, both edges included, leaves the level unchanged.
- R6: The level stays within 0 to 7 and never wraps. A step request at either limit changes nothing and does not start a settling period. The level never moves by more than one per cycle.
- R7: After a level change, the next N valid strobes are ignored, where N is the settling length. Strobes count toward N whether or not automatic mode is on. N=0 means no settling period.
- R8: While `auto_en` is low the level holds its last value, whatever counts arrive.
- R9: While the low threshold is greater than the high threshold, the level never changes.
- R10: Without `pk_valid`, the level does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the threshold word, 1 selects the settling length |
| cfg_wdata | input | 16 | Configuration write data |
| auto_en | input | 1 | Automatic equalization enable |
| pk_valid | input | 1 | Peak count valid strobe |
| pk_count | input | 8 | Peak detector count |
| eq_level | output | 3 | Selected equalization level |

## Verification
A vector table walks the level from 0 to 7 and back to 0. It uses counts one below, at and one above each threshold edge. This separates strict from inclusive comparison and shows the up step apart from the down step. Runs of identical counts at the limits show saturation as opposed to wrap-around. Counts sent with automatic mode off, or with no strobe, must leave the level still. Directed sequences count the skipped samples at the default and at a short settling length, so an off-by-one in the hold-off shows up. They also load an inverted window, and change a threshold so that one count changes its verdict.

// File: rtl/eqsel_pkg.sv
package eqsel_pkg;
   typedef enum logic [1:0] {
      STEP_KEEP = 2'd0,
      STEP_DOWN = 2'd1,
      STEP_UP   = 2'd2
   } step_e;
endpackage

// File: rtl/eqsel_cfg.sv
module eqsel_cfg #(
   parameter int CNT_W    = 8,
   parameter int HOLD_W   = 8,
   parameter int HOLD_DEF = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr,
   input  logic                 cfg_sel,
   input  logic [2*CNT_W-1:0]   cfg_wdata,
   output logic [CNT_W-1:0]     thr_hi,
   output logic [CNT_W-1:0]     thr_lo,
   output logic [HOLD_W-1:0]    hold_len
);
   localparam logic [HOLD_W-1:0] HOLD_RST = HOLD_W'(HOLD_DEF);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         thr_hi   <= '0;
         thr_lo   <= '0;
         hold_len <= HOLD_RST;
      end else if (cfg_wr) begin
         if (!cfg_sel) begin
            thr_hi <= cfg_wdata[2*CNT_W-1:CNT_W];
            thr_lo <= cfg_wdata[CNT_W-1:0];
         end else begin
            hold_len <= cfg_wdata[HOLD_W-1:0];
         end
      end
   end
endmodule

// File: rtl/eqsel_decide.sv
module eqsel_decide
   import eqsel_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             sample_en,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] thr_hi,
   input  logic [CNT_W-1:0] thr_lo,
   output step_e            step
);
   logic win_ok;
   logic above;
   logic below;

   assign win_ok = (thr_lo <= thr_hi);
   assign above  = (count > thr_hi);
   assign below  = (count < thr_lo);

   always_comb begin
      step = STEP_KEEP;
      if (sample_en && win_ok) begin
         if (above)      step = STEP_DOWN;
         else if (below) step = STEP_UP;
      end
   end
endmodule

// File: rtl/eqsel_holdoff.sv
module eqsel_holdoff #(
   parameter int HOLD_W  = 8,
   parameter bit HOLD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pk_valid,
   input  logic              changed,
   input  logic [HOLD_W-1:0] hold_len,
   output logic              busy
);
   generate
      if (HOLD_EN) begin : g_hold
         logic [HOLD_W-1:0] remain;
         always_ff @(posedge clk) begin
            if (!rst_n)                     remain <= '0;
            else if (changed)               remain <= hold_len;
            else if (pk_valid && remain != '0) remain <= remain - 1'b1;
         end
         assign busy = (remain != '0);
      end else begin : g_nohold
         logic unused;
         assign unused = ^{clk, rst_n, pk_valid, changed, hold_len};
         assign busy   = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/eqsel_level.sv
module eqsel_level
   import eqsel_pkg::*;
#(
   parameter int LVL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  step_e            step,
   output logic [LVL_W-1:0] level,
   output logic             changed
);
   localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};
   localparam logic [LVL_W-1:0] LVL_MIN = '0;

   logic [LVL_W-1:0] nxt;

   always_comb begin
      nxt = level;
      case (step)
         STEP_DOWN: if (level != LVL_MIN) nxt = level - 1'b1;
         STEP_UP:   if (level != LVL_MAX) nxt = level + 1'b1;
         default:   nxt = level;
      endcase
   end

   assign changed = (nxt != level);

   always_ff @(posedge clk) begin
      if (!rst_n) level <= LVL_MIN;
      else        level <= nxt;
   end
endmodule

// File: rtl/eq_level_sel.sv
module eq_level_sel
   import eqsel_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int LVL_W    = 3,
   parameter int HOLD_W   = 8,
   parameter int HOLD_DEF = 16,
   parameter bit HOLD_EN  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_wr,
   input  logic                cfg_sel,
   input  logic [2*CNT_W-1:0]  cfg_wdata,
   input  logic                auto_en,
   input  logic                pk_valid,
   input  logic [CNT_W-1:0]    pk_count,
   output logic [LVL_W-1:0]    eq_level
);
   generate
      if (CNT_W < 1 || LVL_W < 1 || HOLD_W < 1)
         $error("eq_level_sel: widths must be positive");
      if (HOLD_W > 2*CNT_W)
         $error("eq_level_sel: settling length wider than write data");
      if (HOLD_DEF >= (1 << HOLD_W) || HOLD_DEF < 0)
         $error("eq_level_sel: default settling length out of range");
   endgenerate

   logic [CNT_W-1:0]  thr_hi;
   logic [CNT_W-1:0]  thr_lo;
   logic [HOLD_W-1:0] hold_len;
   logic              hold_busy;
   logic              lvl_changed;
   logic              sample_en;
   step_e             step;

   eqsel_cfg #(.CNT_W(CNT_W), .HOLD_W(HOLD_W), .HOLD_DEF(HOLD_DEF)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .thr_hi(thr_hi), .thr_lo(thr_lo),
      .hold_len(hold_len)
   );

   assign sample_en = pk_valid && auto_en && !hold_busy;

   eqsel_decide #(.CNT_W(CNT_W)) u_decide (
      .sample_en(sample_en), .count(pk_count), .thr_hi(thr_hi),
      .thr_lo(thr_lo), .step(step)
   );

   eqsel_level #(.LVL_W(LVL_W)) u_level (
      .clk(clk), .rst_n(rst_n), .step(step), .level(eq_level),
      .changed(lvl_changed)
   );

   eqsel_holdoff #(.HOLD_W(HOLD_W), .HOLD_EN(HOLD_EN)) u_hold (
      .clk(clk), .rst_n(rst_n), .pk_valid(pk_valid), .changed(lvl_changed),
      .hold_len(hold_len), .busy(hold_busy)
   );
endmodule

// File: rtl/eqsel_chk.sv
module eqsel_chk #(
   parameter int CNT_W = 8,
   parameter int LVL_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             auto_en,
   input logic             pk_valid,
   input logic [CNT_W-1:0] pk_count,
   input logic [LVL_W-1:0] eq_level,
   input logic [CNT_W-1:0] thr_hi,
   input logic [CNT_W-1:0] thr_lo,
   input logic             hold_busy
);
   logic [LVL_W:0] lvl_x;
   logic           live;
   assign lvl_x = {1'b0, eq_level};
   assign live  = pk_valid && auto_en && !hold_busy && (thr_lo <= thr_hi);

   assert_unit_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (eq_level != $past(eq_level)) |->
         ((lvl_x == $past(lvl_x) + 1'b1) || (lvl_x + 1'b1 == $past(lvl_x))));

   assert_manual_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_en |=> $stable(eq_level));

   assert_no_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !pk_valid |=> $stable(eq_level));

   assert_settle_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hold_busy |=> $stable(eq_level));

   assert_bad_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_lo > thr_hi) |=> $stable(eq_level));

   assert_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pk_valid && pk_count >= thr_lo && pk_count <= thr_hi) |=> $stable(eq_level));

   assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (live && pk_count > thr_hi && eq_level != '0) |=> (lvl_x + 1'b1 == $past(lvl_x)));

   assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (live && pk_count < thr_lo && eq_level != {LVL_W{1'b1}}) |=> (lvl_x == $past(lvl_x) + 1'b1));
endmodule

bind eq_level_sel eqsel_chk #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .auto_en(auto_en), .pk_valid(pk_valid),
   .pk_count(pk_count), .eq_level(eq_level), .thr_hi(thr_hi),
   .thr_lo(thr_lo), .hold_busy(hold_busy)
);

// File: tb/tb_eq_level_sel.sv
module tb_eq_level_sel;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_wr;
   logic        cfg_sel;
   logic [15:0] cfg_wdata;
   logic        auto_en;
   logic        pk_valid;
   logic [7:0]  pk_count;
   logic [2:0]  eq_level;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   eq_level_sel dut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .auto_en(auto_en), .pk_valid(pk_valid),
      .pk_count(pk_count), .eq_level(eq_level)
   );

   // {auto, count, expected level}; window low=0x40 high=0xC0, settling 0
   localparam int NV = 22;
   localparam logic [11:0] VEC [NV] = '{
      {1'b1, 8'h10, 3'd1}, {1'b1, 8'h3F, 3'd2}, {1'b1, 8'h40, 3'd2},
      {1'b1, 8'hC0, 3'd2}, {1'b1, 8'h80, 3'd2}, {1'b1, 8'h00, 3'd3},
      {1'b1, 8'h00, 3'd4}, {1'b1, 8'h00, 3'd5}, {1'b1, 8'h00, 3'd6},
      {1'b1, 8'h00, 3'd7}, {1'b1, 8'h00, 3'd7}, {1'b0, 8'h00, 3'd7},
      {1'b0, 8'hFF, 3'd7}, {1'b1, 8'hC1, 3'd6}, {1'b1, 8'hFF, 3'd5},
      {1'b1, 8'hFF, 3'd4}, {1'b1, 8'hFF, 3'd3}, {1'b1, 8'hFF, 3'd2},
      {1'b1, 8'hFF, 3'd1}, {1'b1, 8'hFF, 3'd0}, {1'b1, 8'hFF, 3'd0},
      {1'b1, 8'h41, 3'd0}
   };

   task automatic check(input string req, input logic [2:0] exp);
      total++;
      if (eq_level !== exp) begin
         bad++;
         $display("FAIL %s: level=%0d expected=%0d", req, eq_level, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [15:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic sample(input logic a, input logic [7:0] c);
      @(negedge clk);
      auto_en = a; pk_valid = 1'b1; pk_count = c;
      @(negedge clk);
      pk_valid = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: level=%0d expected=finish", eq_level);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; cfg_wr = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
      auto_en = 1'b0; pk_valid = 1'b0; pk_count = '0;
      do_reset();
      check("R1", 3'd0);
      // R1: reset thresholds are 0 so count 0 is inside the window
      sample(1'b1, 8'h00);
      check("R1", 3'd0);

      // vector table
      wr(1'b0, 16'hC040);
      wr(1'b1, 16'h0000);
      for (int i = 0; i < NV; i++) begin
         logic [2:0] prev;
         string tag;
         prev = eq_level;
         sample(VEC[i][11], VEC[i][10:3]);
         if (!VEC[i][11])                                  tag = "R8";
         else if (VEC[i][10:3] >= 8'h40 && VEC[i][10:3] <= 8'hC0) tag = "R5";
         else if (VEC[i][2:0] == prev)                     tag = "R6";
         else if (VEC[i][2:0] < prev)                      tag = "R3";
         else                                              tag = "R4";
         check(tag, VEC[i][2:0]);
      end

      // R10: counts present without strobe
      @(negedge clk);
      auto_en = 1'b1; pk_count = 8'h00;
      repeat (5) @(negedge clk);
      check("R10", 3'd0);

      // R7: default settling length 16 after reset
      do_reset();
      wr(1'b0, 16'hC040);
      sample(1'b1, 8'h00);
      check("R4", 3'd1);
      for (int i = 0; i < 16; i++) sample(1'b1, 8'h00);
      check("R7", 3'd1);
      sample(1'b1, 8'h00);
      check("R7", 3'd2);
      for (int i = 0; i < 16; i++) sample(1'b0, 8'h80);
      // R7: short settling length, counted with auto off too
      wr(1'b1, 16'h0003);
      sample(1'b1, 8'hFF);
      check("R3", 3'd1);
      sample(1'b0, 8'hFF);
      sample(1'b1, 8'hFF);
      sample(1'b1, 8'hFF);
      check("R7", 3'd1);
      sample(1'b1, 8'hFF);
      check("R7", 3'd0);
      // R6: request at lower limit starts no settling period
      for (int i = 0; i < 3; i++) sample(1'b1, 8'h80);
      sample(1'b1, 8'hFF);
      sample(1'b1, 8'h00);
      check("R6", 3'd1);

      // R9: inverted window
      for (int i = 0; i < 3; i++) sample(1'b1, 8'h80);
      wr(1'b1, 16'h0000);
      wr(1'b0, 16'h4080);
      sample(1'b1, 8'h00);
      check("R9", 3'd1);
      sample(1'b1, 8'hFF);
      check("R9", 3'd1);
      sample(1'b1, 8'h60);
      check("R9", 3'd1);

      // R2: moving the low threshold changes the verdict on one count
      wr(1'b0, 16'hC040);
      sample(1'b1, 8'h50);
      check("R2", 3'd1);
      wr(1'b0, 16'hC060);
      sample(1'b1, 8'h50);
      check("R2", 3'd2);
      wr(1'b0, 16'h4F20);
      sample(1'b1, 8'h50);
      check("R2", 3'd1);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule